// File: doc/BRIEF.md
# Oscillator Configuration Channel Engine

This block runs a small command and status channel over an array of oscillator setting words. Software first loads a data word into the output-data register. It then writes a control word that names a device index and a function code, and that carries a direction flag and a start flag. One clock later the engine carries out the request. A write copies the output-data word into the selected oscillator entry. A read copies the selected entry into the return-data register. The engine then posts completion status, with an error flag when the request is not legal.

Only function code 1 is legal, and only with a device index below the number of oscillators. Every other request still completes, but with the error flag raised and with no effect on the data. Any write to the control register clears the status. A second control write that lands while a request is still waiting to run replaces that request. A separate combinational read port lets the rest of the chip see any oscillator entry at any time.

Top module: `cfg_chan_engine`

## Requirements
- R1: The control register stores only the device index (bits [11:0]), the function code (bits [25:20]) and the write flag (bit 30). Bits [19:12], bits [29:26] and the start bit (bit 31) always read back as 0.
- R2: Every control write clears the status register, in which DONE is bit 0 and ERROR is bit 1. The cleared value is visible in the cycle after the write, even when no start is requested.
- R3: When a control write has bit 31 set and no further control write follows in the next cycle, DONE reads 1 two cycles after the write. In the cycle between, DONE reads 0.
- R4: A request whose function code is not 1, or whose device index is not below N_OSC, completes with DONE=1 and ERROR=1. It leaves both the return-data register and the oscillator array unchanged.
- R5: A legal request with bit 30 set copies the output-data register into the oscillator entry chosen by the device index.
- R6: A legal request with bit 30 clear loads the chosen oscillator entry into the return-data register.
- R7: After reset, the control register reads 0x00100000, and status, output data and return data read 0. Each oscillator entry i reads OSC_INIT[32*i+31:32*i].
- R8: A control write in the cycle in which a pending request would run cancels that request. Only the newest request is carried out.
- R9: The output-data register takes the write data on its strobe. A transaction running in that same cycle uses the value the register held before the strobe.
- R10: osc_rdata shows oscillator entry osc_raddr, or 0 when osc_raddr is not below N_OSC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 32 | Control register write data |
| dout_we | input | 1 | Output-data register write strobe |
| dout_wdata | input | 32 | Output-data register write data |
| osc_raddr | input | 12 | Oscillator read port index |
| ctrl_q | output | 32 | Control register contents |
| dout_q | output | 32 | Output-data register contents |
| rtn_q | output | 32 | Return-data register contents |
| stat_q | output | 2 | Status: bit 0 DONE, bit 1 ERROR |
| osc_rdata | output | 32 | Oscillator entry selected by osc_raddr |

## Verification
Two events can fall on the same edge, and the bench forces both. In the first, a pending request reaches its execution cycle at the same moment a new control write or an output-data write arrives. The bench provokes this with back-to-back control writes, and with an output-data strobe issued one cycle after a start. It then judges the outcome against a behavioural model that holds pending requests in a queue and samples the old output-data value. The result must show the new request replacing the old one, and the write using the pre-strobe data.

// File: rtl/cfg_chan_engine.sv
module cfg_chan_engine #(
  parameter int N_OSC = 4,
  parameter logic [N_OSC*32-1:0] OSC_INIT = {32'h02FA_F080, 32'h017D_7840, 32'h00B7_1B00, 32'h0165_A0BC}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_we,
  input  logic [31:0] ctrl_wdata,
  input  logic        dout_we,
  input  logic [31:0] dout_wdata,
  input  logic [11:0] osc_raddr,
  output logic [31:0] ctrl_q,
  output logic [31:0] dout_q,
  output logic [31:0] rtn_q,
  output logic [1:0]  stat_q,
  output logic [31:0] osc_rdata
);
  localparam logic [31:0] KEEP_MASK = 32'h43F0_0FFF;
  localparam logic [31:0] CTRL_RST  = 32'h0010_0000;

  logic [31:0] osc [N_OSC];
  logic        pend;
  logic [31:0] sel_val;

  wire [11:0] dev   = ctrl_q[11:0];
  wire [5:0]  func  = ctrl_q[25:20];
  wire        wr    = ctrl_q[30];
  wire        legal = (func == 6'd1) && ({20'd0, dev} < 32'(N_OSC));
  wire        fire  = pend && !ctrl_we;

  always_comb begin
    sel_val   = '0;
    osc_rdata = '0;
    for (int i = 0; i < N_OSC; i++) begin
      if (dev == 12'(i))       sel_val   = osc[i];
      if (osc_raddr == 12'(i)) osc_rdata = osc[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      dout_q <= '0;
      rtn_q  <= '0;
      stat_q <= '0;
      pend   <= 1'b0;
    end else begin
      if (dout_we) dout_q <= dout_wdata;
      if (ctrl_we) begin
        ctrl_q <= ctrl_wdata & KEEP_MASK;
        stat_q <= '0;
        pend   <= ctrl_wdata[31];
      end else if (pend) begin
        pend   <= 1'b0;
        stat_q <= {!legal, 1'b1};
        if (legal && !wr) rtn_q <= sel_val;
      end
    end
  end

  for (genvar g = 0; g < N_OSC; g++) begin : g_osc
    always_ff @(posedge clk) begin
      if (!rst_n)
        osc[g] <= OSC_INIT[g*32 +: 32];
      else if (fire && wr && legal && dev == 12'(g))
        osc[g] <= dout_q;
    end
  end

  a_r2_write_clears_status: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> stat_q == 2'b00);
  a_r3_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && ctrl_wdata[31]) ##1 !ctrl_we |=> stat_q[0]);
  a_r4_error_implies_done: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[1] |-> stat_q[0]);
  a_r4_error_keeps_return: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[1]) |-> $stable(rtn_q));
  a_r6_return_moves_on_success: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rtn_q) |-> stat_q == 2'b01);
  a_r9_dout_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_we |=> $stable(dout_q));
endmodule

// File: tb/cfg_chan_engine_tb.sv
module cfg_chan_engine_tb_top;
  localparam int NO = 4;
  localparam logic [NO*32-1:0] INIT = {32'hA4A4_0004, 32'hA3A3_0003, 32'hA2A2_0002, 32'hA1A1_0001};

  logic clk = 0, rst_n = 0;
  logic ctrl_we = 0, dout_we = 0;
  logic [31:0] ctrl_wdata = 0, dout_wdata = 0;
  logic [11:0] osc_raddr = 0;
  logic [31:0] ctrl_q, dout_q, rtn_q, osc_rdata;
  logic [1:0]  stat_q;
  int checks = 0, errors = 0;
  string stat_tag = "R3", rtn_tag = "R6";

  always #5 clk = ~clk;

  cfg_chan_engine #(.N_OSC(NO), .OSC_INIT(INIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .dout_we(dout_we), .dout_wdata(dout_wdata), .osc_raddr(osc_raddr),
    .ctrl_q(ctrl_q), .dout_q(dout_q), .rtn_q(rtn_q), .stat_q(stat_q), .osc_rdata(osc_rdata));

  logic [31:0] m_ctrl, m_dout, m_rtn;
  logic [1:0]  m_stat;
  logic [31:0] m_osc [NO];
  int          m_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 32'h0010_0000; m_dout = 0; m_rtn = 0; m_stat = 0;
      for (int i = 0; i < NO; i++) m_osc[i] = INIT[i*32 +: 32];
      m_q.delete();
    end else begin
      automatic logic [31:0] old_dout = m_dout;
      if (dout_we) m_dout = dout_wdata;
      if (ctrl_we) begin
        m_ctrl = ctrl_wdata & 32'h43F0_0FFF;
        m_stat = 0;
        m_q.delete();
        if (ctrl_wdata[31]) m_q.push_back(1);
      end else if (m_q.size() > 0) begin
        automatic int d = int'(m_ctrl[11:0]);
        automatic bit ok = (m_ctrl[25:20] == 6'd1) && (d < NO);
        void'(m_q.pop_front());
        m_stat = ok ? 2'b01 : 2'b11;
        if (ok) begin
          if (m_ctrl[30]) m_osc[d] = old_dout;
          else m_rtn = m_osc[d];
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [31:0] po;
    po = (int'(osc_raddr) < NO) ? m_osc[osc_raddr] : 32'h0;
    chk("R1 ctrl", ctrl_q, m_ctrl);
    chk("R9 dout", dout_q, m_dout);
    chk({stat_tag, " stat"}, {30'd0, stat_q}, {30'd0, m_stat});
    chk({rtn_tag, " rtn"}, rtn_q, m_rtn);
    chk("R10 R5 osc port", osc_rdata, po);
  endtask

  task automatic step(bit cwe, logic [31:0] cw, bit dwe, logic [31:0] dw, logic [11:0] ra);
    @(negedge clk);
    compare_all();
    ctrl_we = cwe; ctrl_wdata = cw; dout_we = dwe; dout_wdata = dw; osc_raddr = ra;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R7 reset state
    chk("R7 ctrl", ctrl_q, 32'h0010_0000);
    chk("R7 stat", {30'd0, stat_q}, 32'd0);
    chk("R7 rtn", rtn_q, 32'd0);
    chk("R7 dout", dout_q, 32'd0);
    osc_raddr = 12'd2;
    #1 chk("R7 osc2", osc_rdata, 32'hA3A3_0003);

    step(1, 32'h8010_0001, 0, 0, 1);            // R6 read dev1
    step(0, 0, 1, 32'h1234_5678, 2);
    step(0, 0, 0, 0, 2);
    step(1, 32'hC010_0002, 0, 0, 2);            // R5 write dev2
    step(0, 0, 0, 0, 2);
    step(0, 0, 0, 0, 2);
    step(1, 32'h8010_0002, 0, 0, 2);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    stat_tag = "R4"; rtn_tag = "R4";
    step(1, 32'h8020_0001, 0, 0, 0);            // R4 bad function
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(1, 32'hC010_0004, 1, 32'hDEAD_BEEF, 3); // R4 device out of range
    step(0, 0, 0, 0, 3);
    step(0, 0, 0, 0, 3);
    step(1, 32'h8010_0FFF, 0, 0, 12'hFFF);
    step(0, 0, 0, 0, 12'hFFF);
    step(0, 0, 0, 0, 0);
    stat_tag = "R2"; rtn_tag = "R1";
    step(1, 32'h3C0F_F003, 0, 0, 0);            // R1 reserved bits, R2 clear without start
    step(0, 0, 0, 0, 0);
    stat_tag = "R8"; rtn_tag = "R8";
    step(1, 32'hC010_0000, 0, 0, 0);            // R8 write replaced by read
    step(1, 32'h8010_0003, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    stat_tag = "R9"; rtn_tag = "R9";
    step(1, 32'hC010_0003, 0, 0, 3);            // R9 dout strobe in execution cycle
    step(0, 0, 1, 32'h5555_AAAA, 3);
    step(0, 0, 0, 0, 3);
    step(0, 0, 0, 0, 3);
    stat_tag = "R3"; rtn_tag = "R6";
    for (int n = 0; n < 400; n++) begin
      automatic logic [31:0] c = {$urandom_range(0,1) == 1, 1'b0, 30'h0} | ($urandom_range(0,1) << 30)
                                 | ($urandom_range(0,3) << 20) | $urandom_range(0,5) | ($urandom() & 32'h3C0F_F000);
      step($urandom_range(0,2) == 0, c, $urandom_range(0,3) == 0, $urandom(), 12'($urandom_range(0,5)));
    end
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule